// File: doc/BRIEF.md
# In-Memory Compute Instruction Controller

This block sits between an external processor and an array of compute-capable memory. The processor pushes commands into an eight-entry queue. The controller takes them out one at a time, in the order they arrived, and runs each one against one of two targets. The first target is a plain data array. The second is a configurable logic array, which holds the operand words for the compute blocks. Every command carries a 2-bit opcode, an address and a data word.

The top address bit picks the target. For the logic array, the lower bits split into a layer field, a block field and an in-layer word index. The layer and block fields together form the row index of the array. A start command captures the configuration of the chosen block and launches the compute engine. The engine is a stub with a fixed latency. For each word of the block, it stores the number of set bits into a scratch buffer. It then copies that buffer back into the data array, where the processor reads the results with ordinary loads. A wait command holds instruction fetch until the engine signals completion.

Top module: `imc_ctrl`

## Requirements
- R1: After reset, cmd_ready_o is 1 and rsp_valid_o is 0. Every word of both arrays reads back as 0.
- R2: The queue holds 8 commands. A push happens only when cmd_valid_i and cmd_ready_o are both 1. cmd_ready_o is 0 while 8 commands are held, and a command offered in that state is dropped.
- R3: Commands execute strictly in push order. Load responses leave in the same order as their loads were pushed.
- R4: With 8-bit addresses, bit 7 selects the target (0 = data array, 1 = logic array). The data array decodes only bits 2:0 and ignores bits 6:3. The logic array decodes bits 6:5 as the layer, bits 4:3 as the block and bits 2:0 as the in-layer word.
- R5: Opcode 00 (store) writes the data field to the addressed word. Opcode 01 (load) returns the addressed word on rsp_data_o, with rsp_valid_o high for exactly one cycle per load.
- R6: Opcode 10 (start) captures the 8 configuration words of the block named by its layer and block fields. After the compute latency, data word k holds the number of set bits in configuration word k, for every k in 0..7.
- R7: A start that reaches the head of the queue while the engine is busy is held there until the engine has finished. Its results then replace the earlier results.
- R8: Opcode 11 (wait) holds every later command until the running computation completes. With the engine idle, wait passes at once.
- R9: Stores and loads that target the data array are held while the engine is busy. This means a data store queued behind a start lands after the write-back.
- R10: A configuration store executed while a computation runs changes the logic array but not the running computation's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Queue can accept a command |
| cmd_op_i | input | 2 | Opcode: 00 store, 01 load, 10 start, 11 wait |
| cmd_addr_i | input | ADDR_W | Target, layer, block and word address |
| cmd_data_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Load response strobe |
| rsp_data_o | output | DATA_W | Load response data |

## Verification
Two functions compete for the data array in the same cycle: the engine's result write-back, and a data-array store or load taken from the queue. The bench provokes this by placing a data store directly behind a start, with no wait between them. The store is therefore eligible while the engine is still running. The outcome is judged at the ports. The stored word must read back with the processor's value. Its neighbours must read back with the computed bit counts. This shows the queued access was held until the write-back had finished.

A second overlap is a configuration store that runs in the same window as a computation. The bench judges it by checking two things: the result for that word still reflects the old configuration, and the logic array now holds the new value.

// File: rtl/imc_ctrl_pkg.sv
package imc_ctrl_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'b00,
    OP_LOAD  = 2'b01,
    OP_START = 2'b10,
    OP_WAIT  = 2'b11
  } imc_op_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RUN,
    ENG_WB
  } eng_state_e;
endpackage

// File: rtl/imc_cmd_fifo.sv
module imc_cmd_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign ready_o = cnt < CW'(DEPTH);
  assign empty_o = cnt == '0;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt < CW'(DEPTH));

  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/imc_addr_dec.sv
module imc_addr_dec #(
  parameter int ADDR_W  = 8,
  parameter int LAYER_W = 2,
  parameter int BLOCK_W = 2
) (
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           is_logic_o,
  output logic [LAYER_W+BLOCK_W-1:0]     row_o,
  output logic [ADDR_W-LAYER_W-BLOCK_W-2:0] col_o
);
  localparam int ROW_W = LAYER_W + BLOCK_W;
  localparam int INL_W = ADDR_W - 1 - ROW_W;

  // row = {layer, block}; data target uses col only
  assign is_logic_o = addr_i[ADDR_W-1];
  assign row_o      = addr_i[ADDR_W-2 -: ROW_W];
  assign col_o      = addr_i[INL_W-1:0];
endmodule

// File: rtl/imc_engine.sv
module imc_engine
  import imc_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WORDS    = 8,
  parameter int COMP_LAT = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [WORDS*DATA_W-1:0]    cfg_i,
  output logic                       busy_o,
  output logic                       wb_we_o,
  output logic [$clog2(WORDS)-1:0]   wb_idx_o,
  output logic [DATA_W-1:0]          wb_data_o,
  output logic                       done_o
);
  localparam int IW = $clog2(WORDS);
  localparam int CW = $clog2(COMP_LAT + 1);

  eng_state_e        state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] scratch [WORDS];

  function automatic logic [DATA_W-1:0] bit_count(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) s = s + DATA_W'(v[i]);
    return s;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      idx   <= '0;
      for (int k = 0; k < WORDS; k++) scratch[k] <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (start_i) begin
          for (int k = 0; k < WORDS; k++)
            scratch[k] <= bit_count(cfg_i[k*DATA_W +: DATA_W]);
          cnt   <= CW'(COMP_LAT - 1);
          state <= ENG_RUN;
        end
        ENG_RUN: begin
          if (cnt == '0) begin
            idx   <= '0;
            state <= ENG_WB;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_WB: begin
          idx <= idx + 1'b1;
          if (idx == IW'(WORDS - 1)) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o    = state != ENG_IDLE;
  assign wb_we_o   = state == ENG_WB;
  assign wb_idx_o  = idx;
  assign wb_data_o = scratch[idx];
  assign done_o    = wb_we_o && idx == IW'(WORDS - 1);

  // R7
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state == ENG_IDLE);

  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LAYER_W    = 2,
  parameter int BLOCK_W    = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int COMP_LAT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int ROW_W  = LAYER_W + BLOCK_W;
  localparam int INL_W  = ADDR_W - 1 - ROW_W;
  localparam int WORDS  = 1 << INL_W;
  localparam int LDEPTH = 1 << (ADDR_W - 1);
  localparam int CMD_W  = 2 + ADDR_W + DATA_W;

  logic             q_empty, q_pop;
  logic [CMD_W-1:0] q_head;
  imc_op_e          h_op;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;

  imc_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cmd_valid_i && cmd_ready_o),
    .data_i  ({cmd_op_i, cmd_addr_i, cmd_data_i}),
    .ready_o (cmd_ready_o),
    .pop_i   (q_pop),
    .empty_o (q_empty),
    .head_o  (q_head)
  );

  assign h_op   = imc_op_e'(q_head[CMD_W-1 -: 2]);
  assign h_addr = q_head[DATA_W +: ADDR_W];
  assign h_data = q_head[DATA_W-1:0];

  logic             is_logic;
  logic [ROW_W-1:0] row;
  logic [INL_W-1:0] col;

  imc_addr_dec #(.ADDR_W(ADDR_W), .LAYER_W(LAYER_W), .BLOCK_W(BLOCK_W)) u_dec (
    .addr_i     (h_addr),
    .is_logic_o (is_logic),
    .row_o      (row),
    .col_o      (col)
  );

  logic [DATA_W-1:0] cfg_mem  [LDEPTH];
  logic [DATA_W-1:0] data_mem [WORDS];
  logic [WORDS*DATA_W-1:0] cfg_blk;

  always_comb begin
    for (int k = 0; k < WORDS; k++)
      cfg_blk[k*DATA_W +: DATA_W] = cfg_mem[{row, INL_W'(k)}];
  end

  logic              eng_busy, eng_start, wb_we, eng_done;
  logic [INL_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  imc_engine #(.DATA_W(DATA_W), .WORDS(WORDS), .COMP_LAT(COMP_LAT)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .cfg_i     (cfg_blk),
    .busy_o    (eng_busy),
    .wb_we_o   (wb_we),
    .wb_idx_o  (wb_idx),
    .wb_data_o (wb_data),
    .done_o    (eng_done)
  );

  // issue gate: data-array access and start/wait hold while engine busy
  logic can_go, fire, cfg_we, data_cmd_we, do_load;

  always_comb begin
    unique case (h_op)
      OP_STORE, OP_LOAD: can_go = is_logic || !eng_busy;
      default:           can_go = !eng_busy;
    endcase
  end

  assign fire        = !q_empty && can_go;
  assign q_pop       = fire;
  assign eng_start   = fire && h_op == OP_START;
  assign cfg_we      = fire && h_op == OP_STORE && is_logic;
  assign data_cmd_we = fire && h_op == OP_STORE && !is_logic;
  assign do_load     = fire && h_op == OP_LOAD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LDEPTH; i++) cfg_mem[i] <= '0;
      for (int i = 0; i < WORDS; i++)  data_mem[i] <= '0;
    end else begin
      if (cfg_we) cfg_mem[{row, col}] <= h_data;
      if (wb_we)            data_mem[wb_idx] <= wb_data;
      else if (data_cmd_we) data_mem[col]    <= h_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= do_load;
      if (do_load) rsp_data_o <= is_logic ? cfg_mem[{row, col}] : data_mem[col];
    end
  end

  // R9
  wb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_cmd_we |-> !eng_busy && !wb_we);

  // R5
  load_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!q_empty && h_op == OP_LOAD));

  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_empty && h_op == OP_WAIT && eng_busy && !eng_done) |=> !q_empty && h_op == OP_WAIT);
endmodule

// File: tb/imc_ctrl_test.sv
module imc_ctrl_test;
  localparam int LAT = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;

  always #10 clk = ~clk;

  imc_ctrl #(.COMP_LAT(LAT)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_op_i    (cmd_op),
    .cmd_addr_i  (cmd_addr),
    .cmd_data_i  (cmd_data),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rsp_cnt = 0;
  logic [7:0] rsp_q [64];
  int rsp_cyc [64];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rsp_cnt < 64) begin
        rsp_q[rsp_cnt] = rsp_data;
        rsp_cyc[rsp_cnt] = cyc;
      end
      rsp_cnt++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic try_push(input logic [1:0] op, input logic [7:0] a, output bit acc);
    @(negedge clk);
    acc = cmd_ready;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = '0;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int n);
    for (int t = 0; t < 2000 && rsp_cnt < n; t++) @(negedge clk);
  endtask

  task automatic load_chk(input logic [7:0] a, input int exp, input string tag);
    int b;
    b = rsp_cnt;
    push(2'b01, a, 8'h00);
    wait_rsp(b + 1);
    check(tag, (rsp_cnt > b) ? int'(rsp_q[b]) : -1, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready", cmd_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    load_chk(8'h00, 0, "R1 data word");
    load_chk(8'h80, 0, "R1 logic word");
  endtask

  task automatic t_data_rw;
    push(2'b00, 8'h03, 8'hA5);
    load_chk(8'h03, 8'hA5, "R5 data store/load");
    load_chk(8'h7B, 8'hA5, "R4 data ignores upper bits");
  endtask

  task automatic t_logic;
    push(2'b00, 8'hAB, 8'h3C);
    load_chk(8'hAB, 8'h3C, "R4 logic store/load");
    load_chk(8'h03, 8'hA5, "R4 data untouched by logic store");
    load_chk(8'h8B, 0, "R4 other layer distinct");
  endtask

  task automatic t_order;
    int b;
    b = rsp_cnt;
    push(2'b00, 8'h05, 8'h11);
    push(2'b01, 8'h05, 8'h00);
    push(2'b00, 8'h05, 8'h22);
    push(2'b01, 8'h05, 8'h00);
    wait_rsp(b + 2);
    check("R3 first response", rsp_q[b], 8'h11);
    check("R3 second response", rsp_q[b+1], 8'h22);
    check("R5 one strobe per load", rsp_cnt - b, 2);
  endtask

  task automatic t_compute;
    for (int k = 0; k < 8; k++) push(2'b00, 8'hC8 + 8'(k), 8'((1 << k) - 1));
    push(2'b10, 8'hC8, 8'h00);
    push(2'b11, 8'h00, 8'h00);
    for (int k = 0; k < 8; k++) load_chk(8'(k), k, "R6 bit count result");
  endtask

  task automatic t_wait;
    int b, c0;
    b = rsp_cnt; c0 = cyc;
    push(2'b10, 8'hC8, 8'h00);
    push(2'b11, 8'h00, 8'h00);
    push(2'b01, 8'hC9, 8'h00);
    wait_rsp(b + 1);
    check("R8 wait holds logic load", (rsp_cyc[b] - c0) > LAT, 1);
    check("R8 load data after wait", rsp_q[b], 1);
    b = rsp_cnt; c0 = cyc;
    push(2'b11, 8'h00, 8'h00);
    push(2'b01, 8'hC9, 8'h00);
    wait_rsp(b + 1);
    check("R8 idle wait passes", (rsp_cyc[b] - c0) <= 6, 1);
  endtask

  task automatic t_start_held;
    for (int k = 0; k < 8; k++) push(2'b00, 8'hE0 + 8'(k), 8'hFF);
    push(2'b10, 8'hC8, 8'h00);
    push(2'b10, 8'hE0, 8'h00);
    push(2'b11, 8'h00, 8'h00);
    load_chk(8'h00, 8, "R7 second start result w0");
    load_chk(8'h07, 8, "R7 second start result w7");
  endtask

  task automatic t_data_hold;
    push(2'b10, 8'hC8, 8'h00);
    push(2'b00, 8'h02, 8'h77);
    push(2'b11, 8'h00, 8'h00);
    load_chk(8'h02, 8'h77, "R9 store after write-back");
    load_chk(8'h03, 3, "R9 neighbour keeps result");
  endtask

  task automatic t_snapshot;
    push(2'b10, 8'hC8, 8'h00);
    push(2'b00, 8'hCD, 8'h00);
    push(2'b11, 8'h00, 8'h00);
    load_chk(8'h05, 5, "R10 result from captured config");
    load_chk(8'hCD, 0, "R10 config store applied");
  endtask

  task automatic t_full;
    int b, n_acc;
    bit acc;
    push(2'b10, 8'hE0, 8'h00);
    push(2'b11, 8'h00, 8'h00);
    b = rsp_cnt; n_acc = 0;
    for (int i = 0; i < 10; i++) begin
      try_push(2'b01, 8'(i % 8), acc);
      if (acc) n_acc++;
    end
    check("R2 accepted until full", n_acc, 7);
    @(negedge clk);
    check("R2 ready low when full", cmd_ready, 0);
    wait_rsp(b + 7);
    for (int i = 0; i < 7; i++) check("R2 queued load result", rsp_q[b+i], 8);
    repeat (20) @(negedge clk);
    check("R2 refused pushes dropped", rsp_cnt - b, 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_data_rw();
    t_logic();
    t_order();
    t_compute();
    t_wait();
    t_start_held();
    t_data_hold();
    t_snapshot();
    t_full();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule